// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This peripheral holds a 24-bit up-counter and two compare references. The first reference, the rise mark, sets the count at which the PWM output goes high. The second reference, the period mark, ends the period: the counter returns to zero and an event is latched in a status bit. Software reaches four 32-bit word registers through a plain write strobe with a word select. Reads are combinational on the same select.

With both references loaded with the same value N, the block gives a periodic tick every N clocks. A single-shot option stops counting after the first period. A level interrupt follows the latched status while the global enable is on. Software acknowledges the status by writing the control word back with the status bit set.

The register port has no back-pressure: a write completes on the clock edge that samples the strobe, and a read is valid while the select is held.

Top module: `dcmp_pwm_timer`

## Requirements
- R1: After synchronous reset, all four registers read zero and both `pwm_out` and `irq` are low.
- R2: Word select 0 is the counter, 1 the rise mark, 2 the period mark and 3 control. Reference reads return the stored 24 bits with bits 31:24 zero. Control readback places count enable at bit 0, output enable at bit 3, single-shot at bit 4, global interrupt enable at bit 5, status at bit 6, counter reset at bit 7, rise-mark interrupt enable at bit 10 and period-mark interrupt enable at bit 11. All other bits read zero.
- R3: While bit 0 is set, the counter rises by one on each clock. While bit 0 is clear, the counter holds.
- R4: When the next count would equal the period mark, the counter goes to zero instead, so the period is N clocks. A period mark of 0 gives a period of 2^24 clocks (0xFFFFFF then 0).
- R5: Every period end sets the status bit. If a period end and a clearing control write fall on the same edge, the status stays set.
- R6: A control write with bit 6 = 1 clears the status. A control write with bit 6 = 0 leaves the status unchanged. In both cases every other control bit takes the written value.
- R7: In single-shot mode (bit 4), a period end also clears bit 0, so the counter rests at zero.
- R8: `pwm_out` goes high on the edge where the counter reaches the rise mark. It goes low at the period end, and the period end wins if both happen on the same edge. It is also cleared by a counter write or a counter reset. The output is forced low whenever bit 3 is clear.
- R9: `irq` is high exactly while the status bit and bit 5 are both set.
- R10: With bit 10 set, reaching the rise mark also sets the status. With bit 10 clear, it does not. Bit 11 is stored and read back, and period ends set the status whether or not bit 11 is set.
- R11: A write to the counter loads bits 23:0 and takes priority over counting on that edge. A control write with bit 7 set clears the counter, and bit 7 always reads back as 0.
- R12: Writing 0 to control stops the count and drives `pwm_out` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_sel | input | 2 | Word select (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| pwm_out | output | 1 | PWM waveform, gated by output enable |
| irq | output | 1 | Level interrupt |

## Verification
Assertions check the following on every cycle:
- the counter holds while idle;
- the counter returns to zero after each period end;
- a counter reset leaves zero;
- a period end leaves the status set and the output low;
- a single-shot period end drops the count enable.

Only the directed scenarios can show:
- the exact period length for a given mark, including the 2^24 wrap;
- the edge on which the output rises;
- readback bit positions;
- read-modify-write acknowledge semantics;
- whether the rise-mark interrupt enable has any effect.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int unsigned DW = 32;
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_RISE = 2'd1;
  localparam logic [1:0] SEL_PER  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_OE    = 3;
  localparam int unsigned B_ONE   = 4;
  localparam int unsigned B_GIE   = 5;
  localparam int unsigned B_STS   = 6;
  localparam int unsigned B_CLR   = 7;
  localparam int unsigned B_RIE   = 10;
  localparam int unsigned B_PIE   = 11;

  typedef struct packed {
    logic run;
    logic oe;
    logic one;
    logic gie;
    logic sts;
    logic rie;
    logic pie;
  } ctrl_t;
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic             clr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] rise_mark,
  input  logic [CNT_W-1:0] per_mark,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             rise_hit
);
  logic [CNT_W-1:0] nxt;
  logic             step;

  assign nxt      = cnt + 1'b1;
  assign step     = run && !load && !clr;
  assign wrap     = step && (nxt == per_mark);
  assign rise_hit = step && (nxt == rise_mark);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= wrap ? '0 : nxt;
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load && !clr) |=> (cnt == $past(cnt)));
  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> (cnt == '0));
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             rise_hit,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] rise_mark,
  output logic [CNT_W-1:0] per_mark,
  output logic             cnt_load,
  output logic             cnt_clr,
  output logic [DW-1:0]    reg_rdata
);
  logic ctrl_wr;
  logic sts_set;
  logic unused_bits;

  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign cnt_load = reg_wr && (reg_sel == SEL_CNT);
  assign cnt_clr  = ctrl_wr && reg_wdata[B_CLR];
  assign sts_set  = wrap || (ctrl.rie && rise_hit);
  assign unused_bits = ^{reg_wdata[DW-1:12], reg_wdata[9:8], reg_wdata[2:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      rise_mark <= '0;
      per_mark  <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_RISE) rise_mark <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_sel == SEL_PER)  per_mark  <= reg_wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl.run <= reg_wdata[B_RUN];
        ctrl.oe  <= reg_wdata[B_OE];
        ctrl.one <= reg_wdata[B_ONE];
        ctrl.gie <= reg_wdata[B_GIE];
        ctrl.rie <= reg_wdata[B_RIE];
        ctrl.pie <= reg_wdata[B_PIE];
      end else if (wrap && ctrl.one) begin
        ctrl.run <= 1'b0;
      end
      if (sts_set)                           ctrl.sts <= 1'b1;
      else if (ctrl_wr && reg_wdata[B_STS])  ctrl.sts <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CNT:  reg_rdata[CNT_W-1:0] = cnt;
      SEL_RISE: reg_rdata[CNT_W-1:0] = rise_mark;
      SEL_PER:  reg_rdata[CNT_W-1:0] = per_mark;
      default: begin
        reg_rdata[B_RUN] = ctrl.run;
        reg_rdata[B_OE]  = ctrl.oe;
        reg_rdata[B_ONE] = ctrl.one;
        reg_rdata[B_GIE] = ctrl.gie;
        reg_rdata[B_STS] = ctrl.sts;
        reg_rdata[B_RIE] = ctrl.rie;
        reg_rdata[B_PIE] = ctrl.pie;
      end
    endcase
  end

  // R5
  wrap_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ctrl.sts);
  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && ctrl.one && !ctrl_wr) |=> !ctrl.run);
endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic wrap,
  input  logic rise_hit,
  input  logic oe,
  input  logic sts,
  input  logic gie,
  output logic pwm_out,
  output logic irq
);
  logic level;

  always_ff @(posedge clk) begin
    if (rst)                   level <= 1'b0;
    else if (restart || wrap)  level <= 1'b0;
    else if (rise_hit)         level <= 1'b1;
  end

  assign pwm_out = level && oe;
  assign irq     = sts && gie;

  // R8
  wrap_drops_pwm_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !pwm_out);
endmodule

// File: rtl/dcmp_pwm_timer.sv
module dcmp_pwm_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          pwm_out,
  output logic          irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, rise_mark, per_mark;
  logic             wrap, rise_hit, cnt_load, cnt_clr;

  pwmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cnt(cnt), .wrap(wrap), .rise_hit(rise_hit),
    .ctrl(ctrl), .rise_mark(rise_mark), .per_mark(per_mark),
    .cnt_load(cnt_load), .cnt_clr(cnt_clr), .reg_rdata(reg_rdata)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl.run), .load(cnt_load), .clr(cnt_clr),
    .load_val(reg_wdata[CNT_W-1:0]), .rise_mark(rise_mark),
    .per_mark(per_mark), .cnt(cnt), .wrap(wrap), .rise_hit(rise_hit)
  );

  pwmt_wave u_wave (
    .clk(clk), .rst(rst), .restart(cnt_load || cnt_clr), .wrap(wrap),
    .rise_hit(rise_hit), .oe(ctrl.oe), .sts(ctrl.sts), .gie(ctrl.gie),
    .pwm_out(pwm_out), .irq(irq)
  );
endmodule

// File: tb/dcmp_pwm_timer_tb.sv
module dcmp_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out, irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  dcmp_pwm_timer u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(2'd3, 32'h40);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v); check("R1 reg", v, 0);
    end
    check("R1 pwm", {31'd0, pwm_out}, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_map();
    wr(2'd1, 32'hFFAB_CDEF); rd(2'd1, v); check("R2 rise", v, 32'h00AB_CDEF);
    wr(2'd2, 32'h0012_3456); rd(2'd2, v); check("R2 period", v, 32'h0012_3456);
    wr(2'd3, 32'hFFFF_FF3E); rd(2'd3, v); check("R2 ctrl bits", v, 32'h0000_0C38);
    wr(2'd3, 32'h0);          rd(2'd3, v); check("R12 ctrl zero", v, 0);
  endtask

  task automatic t_period();
    quiesce();
    wr(2'd1, 5); wr(2'd2, 5); wr(2'd3, 32'h29);
    rd(2'd0, v); check("R3 start", v, 0);
    wait_n(4); rd(2'd0, v); check("R3 count", v, 4);
    check("R9 irq before", {31'd0, irq}, 0);
    wait_n(1); rd(2'd0, v); check("R4 wrap", v, 0);
    check("R9 irq after", {31'd0, irq}, 1);
    rd(2'd3, v); check("R5 status", v, 32'h69);
    wr(2'd3, v);  rd(2'd3, v); check("R6 w1c", v, 32'h29);
    check("R6 irq clear", {31'd0, irq}, 0);
    rd(2'd0, v); check("R3 after ack", v, 1);
    wait_n(3);
    wr(2'd3, 32'h69); rd(2'd3, v); check("R5 set wins", v, 32'h69);
    wr(2'd3, 32'h29); rd(2'd3, v); check("R6 zero keeps", v, 32'h69);
  endtask

  task automatic t_stop();
    wr(2'd3, 32'h0);
    rd(2'd0, v);
    begin
      logic [31:0] w;
      wait_n(3); rd(2'd0, w); check("R12 hold", w, v);
    end
    check("R12 pwm", {31'd0, pwm_out}, 0);
    check("R12 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_pwm();
    quiesce();
    wr(2'd1, 4); wr(2'd2, 10); wr(2'd3, 32'h09);
    wait_n(3); check("R8 low", {31'd0, pwm_out}, 0);
    wait_n(1); check("R8 rise", {31'd0, pwm_out}, 1);
    wait_n(5); check("R8 still high", {31'd0, pwm_out}, 1);
    wait_n(1); check("R8 wrap low", {31'd0, pwm_out}, 0);
    wait_n(4); check("R8 high again", {31'd0, pwm_out}, 1);
    wr(2'd3, 32'h01); check("R8 oe gate", {31'd0, pwm_out}, 0);
    wr(2'd3, 32'h09); check("R8 oe back", {31'd0, pwm_out}, 1);
    wr(2'd0, 32'h2); check("R8 load clears", {31'd0, pwm_out}, 0);
  endtask

  task automatic t_oneshot();
    quiesce();
    wr(2'd1, 3); wr(2'd2, 3); wr(2'd3, 32'h31);
    wait_n(3); rd(2'd3, v); check("R7 run cleared", v, 32'h70);
    wait_n(3); rd(2'd0, v); check("R7 rests", v, 0);
  endtask

  task automatic t_rise_irq();
    quiesce();
    wr(2'd1, 5); wr(2'd2, 20); wr(2'd3, 32'h421);
    wait_n(4); check("R10 before", {31'd0, irq}, 0);
    wait_n(1); check("R10 rise sets", {31'd0, irq}, 1);
    quiesce();
    wr(2'd3, 32'h821);
    wait_n(5); check("R10 no rie", {31'd0, irq}, 0);
    wait_n(15); check("R10 wrap sets", {31'd0, irq}, 1);
  endtask

  task automatic t_counter();
    quiesce();
    wr(2'd0, 32'hAB00_0077); rd(2'd0, v); check("R11 load", v, 32'h77);
    wr(2'd3, 32'h80); rd(2'd0, v); check("R11 reset", v, 0);
    rd(2'd3, v); check("R11 reads zero", v, 0);
    wr(2'd2, 0); wr(2'd0, 32'hFF_FFFE); wr(2'd3, 32'h21);
    rd(2'd0, v); check("R4 max start", v, 32'hFF_FFFE);
    wait_n(1); rd(2'd0, v); check("R4 max top", v, 32'hFF_FFFF);
    check("R4 no irq yet", {31'd0, irq}, 0);
    wait_n(1); rd(2'd0, v); check("R4 max wrap", v, 0);
    check("R4 max irq", {31'd0, irq}, 1);
    wait_n(2);
    wr(2'd0, 32'h10); rd(2'd0, v); check("R11 load wins", v, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_period();
    t_stop();
    t_pwm();
    t_oneshot();
    t_rise_irq();
    t_counter();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule